// File: doc/BRIEF.md
# Sampled Glitch Filter with Edge Interrupt

This block cleans up one asynchronous input pin and reports its transitions. The pin first passes through a two-stage synchronizer. A free-running prescaler produces sampling strobes at one of four software-chosen rates. On every strobe the synchronized level is shifted into a short history. The filtered level takes a new value only when every entry in that history agrees.

Rising and falling transitions of the filtered level are each reported as one-cycle pulses. An edge-select field chooses which polarity sets a sticky interrupt flag. Software clears the flag with a one-cycle clear pulse. A slow sampling rate rejects long bursts such as contact bounce, at the price of a longer detection delay.

Top module: `pin_glitch_filter`

## Requirements
- R1: `rate_sel` sets the sampling period P in system clocks: code 00 gives P=1, 01 gives P=4, 10 gives P=16 and 11 gives P=64.
- R2: A new level is accepted only after 4 consecutive samples agree. From the cycle the pin is driven to the new level, `level_o` takes that level after a delay of 3P+3 to 4P+2 rising clock edges. This delay includes the two-edge synchronizer.
- R3: A pulse of the opposite level that lasts 3P clocks or less leaves `level_o` unchanged. It produces no edge pulse and no interrupt.
- R4: `level_o` changes only on clock edges where a sampling strobe is active.
- R5: `rise_o` is high for exactly the first cycle in which `level_o` is 1 after being 0. `fall_o` behaves the same way for the 1-to-0 transition.
- R6: `rise_o` and `fall_o` are never high in the same cycle.
- R7: The `edge_sel` encoding is 00 none, 01 rising only, 10 falling only, 11 both. A qualifying edge pulse sets `irq_o` on the next clock edge, and `irq_o` stays 0 when no qualifying edge occurs.
- R8: `irq_o` is sticky until a one-cycle `irq_clr`. When a qualifying edge and a clear fall in the same cycle, the flag stays set.
- R9: Reset is synchronous and active low. During reset the filtered level and the whole sample history load the synchronized pin value. After reset `irq_o` is 0 and no edge pulse appears while the pin is steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_raw | input | 1 | Asynchronous input pin |
| rate_sel | input | 2 | Sampling period select |
| edge_sel | input | 2 | Interrupt edge polarity select |
| irq_clr | input | 1 | One-cycle clear of the interrupt flag |
| level_o | output | 1 | Filtered pin level |
| rise_o | output | 1 | One-cycle rising-edge pulse |
| fall_o | output | 1 | One-cycle falling-edge pulse |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
The hardest case to reach from the ports is a clear pulse that lands exactly in the cycle in which a qualifying edge pulse is visible. To hit it, the bench watches `rise_o` at the falling clock edge and raises `irq_clr` in that same half cycle. Short glitch widths and long level changes are also drawn at random for every sampling rate. Widths between 3P and 4P clocks are avoided, because the outcome there depends on the strobe phase, so each drawn pulse has a single expected result.

// File: rtl/sgf_pkg.sv
// Shared types for the sampled glitch filter.
// Assumes a 2-bit edge-select field; the encoding is fixed here for all users.
package sgf_pkg;
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_evt_t;
endpackage

// File: rtl/sgf_sync.sv
// Multi-stage synchronizer for an asynchronous level.
// Assumes the input is a slow level signal. The stages carry no reset, so
// they keep tracking the pin while the rest of the block is held in reset.
module sgf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/sgf_prescaler.sv
// Free-running prescaler producing a sampling strobe.
// Rate code k gives one strobe every 2**(STEP_LOG2*k) clocks; code 0 strobes
// every cycle. Assumes the counter wraps freely and rate changes need no sync.
module sgf_prescaler #(
    parameter int SEL_W     = 2,
    parameter int STEP_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             tick
);
    localparam int NRATES = 2 ** SEL_W;
    localparam int CNT_W  = STEP_LOG2 * (NRATES - 1);

    logic [CNT_W-1:0]  cnt;
    logic [NRATES-1:0] taps;

    // Advance the free-running divide counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // One strobe tap per selectable rate.
    for (genvar k = 0; k < NRATES; k++) begin : g_tap
        if (k == 0) begin : g_full
            assign taps[k] = 1'b1;
        end else begin : g_div
            assign taps[k] = (cnt[STEP_LOG2*k-1:0] == '0);
        end
    end

    assign tick = taps[rate_sel];
endmodule

// File: rtl/sgf_filter.sv
// Majority-free agreement filter: the output follows the input only after
// AGREE consecutive strobed samples are equal. Assumes din is synchronous.
// Reset loads the whole history and the output with din (no false edge).
module sgf_filter #(
    parameter int AGREE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din,
    output logic filt
);
    logic [AGREE-1:0] hist;
    logic [AGREE-1:0] hist_nxt;

    // History after the current sample is taken.
    always_comb begin
        hist_nxt = {hist[AGREE-2:0], din};
    end

    // Shift samples on strobes and accept a level once all agree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= {AGREE{din}};
            filt <= din;
        end else if (tick) begin
            hist <= hist_nxt;
            if (&hist_nxt)       filt <= 1'b1;
            else if (~|hist_nxt) filt <= 1'b0;
        end
    end
endmodule

// File: rtl/sgf_edge_irq.sv
// Edge detector on the filtered level plus a sticky interrupt flag.
// Assumes init_lvl equals the value the filter loads in reset, so the
// previous-level register starts equal to the filtered level.
module sgf_edge_irq
    import sgf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      filt,
    input  logic      init_lvl,
    input  edge_sel_e edge_sel,
    input  logic      irq_clr,
    output edge_evt_t evt,
    output logic      irq
);
    logic prev;
    logic qual;

    // Remember the filtered level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= init_lvl;
        else        prev <= filt;
    end

    // Decode edges and whether the selected polarity matched.
    always_comb begin
        evt.rise = filt & ~prev;
        evt.fall = ~filt & prev;
        qual     = (evt.rise & edge_sel[0]) | (evt.fall & edge_sel[1]);
    end

    // Sticky flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (qual)    irq <= 1'b1;
        else if (irq_clr) irq <= 1'b0;
    end
endmodule

// File: rtl/pin_glitch_filter.sv
// Top: synchronize a pin, sample it at a selectable rate, accept a level
// after four agreeing samples, report edges and raise a sticky interrupt.
// Assumes rst_n is synchronous to clk and pin_raw is fully asynchronous.
module pin_glitch_filter
    import sgf_pkg::*;
#(
    parameter int SEL_W       = 2,
    parameter int STEP_LOG2   = 2,
    parameter int AGREE       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_raw,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic [1:0]       edge_sel,
    input  logic             irq_clr,
    output logic             level_o,
    output logic             rise_o,
    output logic             fall_o,
    output logic             irq_o
);
    logic      pin_sync;
    logic      samp_tick;
    edge_evt_t evt;

    sgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (pin_raw),
        .q   (pin_sync)
    );

    sgf_prescaler #(.SEL_W(SEL_W), .STEP_LOG2(STEP_LOG2)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .tick     (samp_tick)
    );

    sgf_filter #(.AGREE(AGREE)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (samp_tick),
        .din   (pin_sync),
        .filt  (level_o)
    );

    sgf_edge_irq u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .filt     (level_o),
        .init_lvl (pin_sync),
        .edge_sel (edge_sel_e'(edge_sel)),
        .irq_clr  (irq_clr),
        .evt      (evt),
        .irq      (irq_o)
    );

    assign rise_o = evt.rise;
    assign fall_o = evt.fall;
endmodule

// File: rtl/pin_glitch_filter_chk.sv
// Property checker for pin_glitch_filter, attached by bind.
// Assumes it sees the sampling strobe and the synchronized pin from the top.
module pin_glitch_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       sync_lvl,
    input logic       level,
    input logic       rise,
    input logic       fall,
    input logic [1:0] edge_sel,
    input logic       irq_clr,
    input logic       irq
);
    logic qual;
    assign qual = (rise && edge_sel[0]) || (fall && edge_sel[1]);

    p_strobe_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(level)) |-> $past(tick));

    p_agree_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(level)) |-> (level == $past(sync_lvl)));

    p_rise_on_rose_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(level)) |-> rise);

    p_fall_on_fell_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(level)) |-> fall);

    p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    p_edges_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));

    p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> irq);

    p_irq_hold_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !qual) |=> !irq);

    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !qual) |=> !irq);
endmodule

bind pin_glitch_filter pin_glitch_filter_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (samp_tick),
    .sync_lvl (pin_sync),
    .level    (level_o),
    .rise     (rise_o),
    .fall     (fall_o),
    .edge_sel (edge_sel),
    .irq_clr  (irq_clr),
    .irq      (irq_o)
);

// File: tb/pin_glitch_filter_bench.sv
module pin_glitch_filter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_raw = 1'b1;
    logic [1:0] rate_sel = 2'b00;
    logic [1:0] edge_sel = 2'b00;
    logic       irq_clr = 1'b0;
    logic       level_o, rise_o, fall_o, irq_o;

    int n_checks = 0;
    int n_fail = 0;
    int n_rise = 0;
    int n_fall = 0;
    int exp_rise = 0;
    int exp_fall = 0;
    int both_bad = 0;
    int wide_bad = 0;
    logic rise_prev = 1'b0;
    logic fall_prev = 1'b0;
    logic cur = 1'b1;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pin_glitch_filter u_pin_glitch_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_raw),
        .rate_sel (rate_sel),
        .edge_sel (edge_sel),
        .irq_clr  (irq_clr),
        .level_o  (level_o),
        .rise_o   (rise_o),
        .fall_o   (fall_o),
        .irq_o    (irq_o)
    );

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            n_rise = n_rise + int'(rise_o);
            n_fall = n_fall + int'(fall_o);
            if (rise_o && fall_o) both_bad++;
            if ((rise_o && rise_prev) || (fall_o && fall_prev)) wide_bad++;
            rise_prev = rise_o;
            fall_prev = fall_o;
        end
    end

    function automatic int period(input logic [1:0] s);
        return 1 << (2 * s);
    endfunction

    function automatic logic exp_irq(input logic [1:0] sel, input logic rising);
        return rising ? sel[0] : sel[1];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    // Change the level and measure the latency (R1, R2, R5, R7).
    task automatic do_change(input string req);
        int p;
        int d;
        logic nv;
        p = period(rate_sel);
        nv = ~cur;
        clear_irq();
        @(negedge clk);
        pin_raw = nv;
        d = 0;
        while (d < 600) begin
            @(negedge clk);
            d++;
            if (level_o == nv) break;
        end
        check((d >= 3*p + 3) && (d <= 4*p + 2), req, d, 4*p + 2);
        cur = nv;
        if (nv) exp_rise++; else exp_fall++;
        repeat (2) @(negedge clk);
        check(irq_o == exp_irq(edge_sel, nv), "R7 irq after edge", int'(irq_o),
              int'(exp_irq(edge_sel, nv)));
        check((n_rise == exp_rise) && (n_fall == exp_fall), "R5 edge count",
              n_rise + n_fall, exp_rise + exp_fall);
    endtask

    // Glitch of width w clocks, at most 3P, must vanish (R3).
    task automatic do_glitch(input int w);
        int p;
        p = period(rate_sel);
        clear_irq();
        @(negedge clk);
        pin_raw = ~cur;
        repeat (w) @(negedge clk);
        pin_raw = cur;
        repeat (4*p + 8) @(negedge clk);
        check(level_o == cur, "R3 level kept", int'(level_o), int'(cur));
        check((n_rise == exp_rise) && (n_fall == exp_fall), "R3 no edge",
              n_rise + n_fall, exp_rise + exp_fall);
        check(irq_o == 1'b0, "R3 no irq", int'(irq_o), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset loads the synchronized level, no edges, no interrupt.
        check(level_o == 1'b1, "R9 level after reset", int'(level_o), 1);
        check(irq_o == 1'b0, "R9 irq after reset", int'(irq_o), 0);
        repeat (10) @(negedge clk);
        check((n_rise == 0) && (n_fall == 0), "R9 no false edge", n_rise + n_fall, 0);

        // R1: each rate code gives its own latency window.
        for (int s = 0; s < 4; s++) begin
            rate_sel = 2'(s);
            edge_sel = 2'b11;
            do_change("R1 latency per rate");
        end

        // R8: clear in the same cycle as a qualifying edge loses to the set.
        rate_sel = 2'b00;
        edge_sel = 2'b01;
        if (cur) do_change("R2 latency");
        clear_irq();
        @(negedge clk);
        pin_raw = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (rise_o) break;
        end
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        cur = 1'b1;
        exp_rise++;
        check(irq_o == 1'b1, "R8 set wins over clear", int'(irq_o), 1);
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check(irq_o == 1'b0, "R8 clear alone", int'(irq_o), 0);

        // R3 boundary: glitch of exactly 3P at the slowest rate.
        rate_sel = 2'b11;
        edge_sel = 2'b11;
        do_glitch(3 * 64);

        // Random mix of glitches and level changes.
        for (int it = 0; it < 40; it++) begin
            rate_sel = 2'($urandom_range(0, 3));
            edge_sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 0) begin
                edge_sel = 2'b11;
                do_glitch($urandom_range(1, 3 * period(rate_sel)));
            end else begin
                do_change("R2 latency");
            end
        end

        check(both_bad == 0, "R6 rise and fall together", both_bad, 0);
        check(wide_bad == 0, "R5 pulse wider than one cycle", wide_bad, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule